// File: doc/BRIEF.md
# Chained Converter Serial Readback Capture

This block collects conversion results from a chain of dual-channel integrating converters whose serial outputs are wired in series. It watches the converters' active-low data-ready line. When that line falls, the block waits a programmable number of system clock cycles, then pulls its active-low transmit request low. It clocks the chain with a data clock that it generates from the 20 MHz system clock, or that arrives from outside, and shifts in one 20-bit result per channel per device. Each finished word is tagged with the integrator side in use and written into a circular capture memory. Once the memory is full, each new word replaces the oldest one.

A host-side port reads the memory. A start pulse takes a snapshot of the write position and fill level. Each read strobe after that returns one entry, from oldest to newest. The chain length is set through a configuration input. A setting of zero is treated as one device, and a setting above the supported maximum is limited to that maximum. The external data clock input shares a board pin with an external conversion-start source. Selecting both at once is flagged, and readback stays blocked while the flag is up.

Top module: `rbcap_top`

## Requirements
- R1: After reset, `xmit_n` is 1, `dclk_out` is 0, `overrun` is 0, `cfg_conflict` is 0, `rd_valid` is 0 and `rd_empty` is 1.
- R2: If the clock edge that first sees `dvalid_n` at 0 (previous sample 1) is edge 0, and the latched delay is D cycles, `xmit_n` goes to 0 on edge D+1.
- R3: With the internal clock, `cfg_rate` codes 0, 1, 2 and 3 give a `dclk_out` period of 2, 4, 8 and 16 system clocks (10, 5, 2.5 and 1.25 MHz from 20 MHz). `dclk_out` is only high while `xmit_n` is 0.
- R4: One readback captures 2·N words of 20 bits each, most significant bit first. Each bit is sampled at a rising data clock. N is the device count latched at the data-ready fall, with 0 treated as 1. With the internal clock, `xmit_n` returns to 1 at the data clock fall that follows the last bit, so exactly 40·N rising edges appear.
- R5: Bit 20 of every stored entry holds the level of `conv_lvl` at the data-ready fall that started the readback. Bits 19..0 hold the word.
- R6: While `cfg_ext_dclk` is 1, `dclk_out` stays 0. Bits are taken on rising edges of `ext_dclk`, after a two-stage synchronizer with a matching delay on `sdata_in`. `xmit_n` returns to 1 right after the last bit is taken.
- R7: When `cfg_ext_dclk` and `cfg_ext_conv` are both 1, `cfg_conflict` is 1 from the next cycle onward. While `cfg_conflict` is 1, a data-ready fall starts no readback and writes nothing.
- R8: The memory holds 2^ADDR_W entries. Once it is full, each new word overwrites the oldest, and a read returns the newest 2^ADDR_W words from oldest to newest.
- R9: `rd_start` snapshots the fill level and the position of the oldest entry, and reading does not remove entries. Each `rd_en` while `rd_empty` is 0 gives `rd_valid` and the entry in the next cycle. An `rd_en` while empty gives no `rd_valid`.
- R10: A data-ready fall that arrives while a readback is waiting or shifting raises `overrun` for exactly one cycle. The current readback still finishes with its full word count, and no new readback starts from that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| dvalid_n | input | 1 | Active-low data-ready from the converter chain |
| conv_lvl | input | 1 | Conversion-control level; gives the integrator side |
| sdata_in | input | 1 | Serial data from the end of the chain |
| ext_dclk | input | 1 | External data clock (shared board pin) |
| cfg_devs | input | DEV_W | Number of chained devices |
| cfg_delay | input | DLY_W | Readback delay in system clock cycles |
| cfg_rate | input | 2 | Internal data clock rate code |
| cfg_ext_dclk | input | 1 | Use the external data clock |
| cfg_ext_conv | input | 1 | External conversion start is in use on the shared pin |
| rd_start | input | 1 | Snapshot the memory for reading |
| rd_en | input | 1 | Read strobe |
| dclk_out | output | 1 | Internal data clock to the chain |
| xmit_n | output | 1 | Active-low transmit request to the chain |
| cfg_conflict | output | 1 | Both shared-pin uses are selected |
| overrun | output | 1 | One-cycle pulse on a data-ready fall during readback |
| rd_data | output | 21 | Entry read: side in bit 20, word in bits 19..0 |
| rd_valid | output | 1 | `rd_data` holds a fresh entry |
| rd_empty | output | 1 | No entries left in the current snapshot |

## Verification
A bit counter that is off by one would show at the ports within a single frame. The number of data clock rising edges between the fall and rise of `xmit_n` would then differ from 40·N, and every word read back afterwards would be shifted. A stale side latch or a wrong write pointer stays hidden until the host reads the memory. At that point the side bit, or the oldest-to-newest order after wraparound, disagrees with the bench's queue of expected words. Errors in the delay counter and the rate divider show up within a few cycles of each frame start, as a wrong start cycle or a wrong data clock period.

// File: rtl/rbcap_pkg.sv
package rbcap_pkg;

    localparam int WORD_W       = 20;
    localparam int CHAN_PER_DEV = 2;
    localparam int PH_W         = 4;
    localparam int SYNC_STAGES  = 2;

    typedef enum logic [1:0] {
        RB_IDLE  = 2'd0,
        RB_WAIT  = 2'd1,
        RB_SHIFT = 2'd2
    } rb_state_e;

    typedef enum logic [1:0] {
        RATE_DIV2  = 2'd0,
        RATE_DIV4  = 2'd1,
        RATE_DIV8  = 2'd2,
        RATE_DIV16 = 2'd3
    } dclk_rate_e;

    typedef struct packed {
        logic              side;
        logic [WORD_W-1:0] data;
    } cap_word_t;

    // Cycles spent in each half of the data clock, minus one.
    function automatic logic [PH_W-1:0] half_limit(input logic [1:0] rate);
        logic [PH_W-1:0] one;
        one = PH_W'(1);
        return (one << rate) - one;
    endfunction

endpackage

// File: rtl/rb_dclk_gen.sv
module rb_dclk_gen
    import rbcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       ext_sel,
    input  logic       ext_dclk,
    input  logic       din,
    output logic       smp_stb,
    output logic       smp_bit,
    output logic       fall_stb,
    output logic       dclk_out
);

    localparam int XS_W = SYNC_STAGES + 1;

    logic [PH_W-1:0]        ph;
    logic [PH_W-1:0]        lim;
    logic                   dclk_q;
    logic                   tick;
    logic [XS_W-1:0]        xs;
    logic [SYNC_STAGES-1:0] ds;
    logic                   ext_rise;

    always_comb lim = half_limit(rate);
    always_comb tick = run && !ext_sel && (ph == lim);

    // internal divider: runs only while shifting and the internal clock is chosen
    always_ff @(posedge clk) begin
        if (rst || !run || ext_sel) begin
            ph     <= '0;
            dclk_q <= 1'b0;
        end else if (ph == lim) begin
            ph     <= '0;
            dclk_q <= ~dclk_q;
        end else begin
            ph <= ph + PH_W'(1);
        end
    end

    // synchronizer for the external clock, data delayed to match
    generate
        for (genvar s = 0; s < XS_W; s++) begin : g_xsync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) xs[s] <= 1'b0;
                    else     xs[s] <= ext_dclk;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) xs[s] <= 1'b0;
                    else     xs[s] <= xs[s-1];
                end
            end
        end
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_dsync
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) ds[s] <= 1'b0;
                    else     ds[s] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) ds[s] <= 1'b0;
                    else     ds[s] <= ds[s-1];
                end
            end
        end
    endgenerate

    always_comb ext_rise = xs[SYNC_STAGES-1] && !xs[SYNC_STAGES];

    always_comb begin
        if (ext_sel) begin
            smp_stb = run && ext_rise;
            smp_bit = ds[SYNC_STAGES-1];
        end else begin
            smp_stb = tick && !dclk_q;
            smp_bit = din;
        end
        fall_stb = tick && dclk_q;
        dclk_out = dclk_q;
    end

endmodule

// File: rtl/rb_sequencer.sv
module rb_sequencer
    import rbcap_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int DEV_W   = 4,
    parameter int DLY_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dvalid_n,
    input  logic             conv_lvl,
    input  logic [DEV_W-1:0] cfg_devs,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             ext_sel,
    input  logic             block_start,
    input  logic             smp_stb,
    input  logic             smp_bit,
    input  logic             fall_stb,
    output logic             run,
    output logic             xmit_n,
    output logic             overrun,
    output logic             wr_en,
    output cap_word_t        wr_word
);

    localparam int BIT_W = $clog2(WORD_W);
    localparam int WC_W  = DEV_W + 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [DEV_W-1:0] DEV_CAP  = DEV_W'(MAX_DEV);

    rb_state_e          state;
    logic               dv_q;
    logic               dv_fall;
    logic [DLY_W-1:0]   dly;
    logic               side_q;
    logic [DEV_W-1:0]   devs_q;
    logic [DEV_W-1:0]   devs_eff;
    logic [BIT_W-1:0]   bit_cnt;
    logic [WC_W-1:0]    word_cnt;
    logic [WC_W-1:0]    last_word;
    logic               last_done;
    logic [WORD_W-2:0]  sreg;
    logic               word_end;

    always_comb dv_fall = dv_q && !dvalid_n;

    always_comb begin
        if (cfg_devs == '0)          devs_eff = DEV_W'(1);
        else if (cfg_devs > DEV_CAP) devs_eff = DEV_CAP;
        else                         devs_eff = cfg_devs;
    end

    always_comb last_word = {devs_q, 1'b0} - WC_W'(1);
    always_comb word_end  = (state == RB_SHIFT) && smp_stb && (bit_cnt == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RB_IDLE;
            dv_q      <= 1'b1;
            xmit_n    <= 1'b1;
            overrun   <= 1'b0;
            dly       <= '0;
            side_q    <= 1'b0;
            devs_q    <= DEV_W'(1);
            bit_cnt   <= '0;
            word_cnt  <= '0;
            last_done <= 1'b0;
            sreg      <= '0;
        end else begin
            dv_q    <= dvalid_n;
            overrun <= dv_fall && (state != RB_IDLE);
            case (state)
                RB_IDLE: begin
                    if (dv_fall && !block_start) begin
                        state  <= RB_WAIT;
                        dly    <= cfg_delay;
                        side_q <= conv_lvl;
                        devs_q <= devs_eff;
                    end
                end
                RB_WAIT: begin
                    if (dly == '0) begin
                        state     <= RB_SHIFT;
                        xmit_n    <= 1'b0;
                        bit_cnt   <= '0;
                        word_cnt  <= '0;
                        last_done <= 1'b0;
                    end else begin
                        dly <= dly - DLY_W'(1);
                    end
                end
                RB_SHIFT: begin
                    if (smp_stb) begin
                        sreg <= {sreg[WORD_W-3:0], smp_bit};
                        if (bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                            if (word_cnt == last_word) begin
                                last_done <= 1'b1;
                                if (ext_sel) begin
                                    state  <= RB_IDLE;
                                    xmit_n <= 1'b1;
                                end
                            end else begin
                                word_cnt <= word_cnt + WC_W'(1);
                            end
                        end else begin
                            bit_cnt <= bit_cnt + BIT_W'(1);
                        end
                    end
                    if (fall_stb && last_done) begin
                        state  <= RB_IDLE;
                        xmit_n <= 1'b1;
                    end
                end
                default: state <= RB_IDLE;
            endcase
        end
    end

    always_comb begin
        run          = (state == RB_SHIFT);
        wr_en        = word_end;
        wr_word.side = side_q;
        wr_word.data = {sreg, smp_bit};
    end

endmodule

// File: rtl/rb_ring.sv
module rb_ring #(
    parameter int ADDR_W = 10,
    parameter int ENT_W  = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [ENT_W-1:0] wr_data,
    input  logic             rd_start,
    input  logic             rd_en,
    output logic [ENT_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_empty
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int FILL_W = ADDR_W + 1;
    localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

    logic [ENT_W-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [FILL_W-1:0] fill;
    logic [ADDR_W-1:0] rd_ptr;
    logic [FILL_W-1:0] rd_left;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + ADDR_W'(1);
            if (fill != FULL) fill <= fill + FILL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            rd_left  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (rd_start) begin
            rd_ptr   <= wr_ptr - fill[ADDR_W-1:0];
            rd_left  <= fill;
            rd_valid <= 1'b0;
        end else if (rd_en && (rd_left != '0)) begin
            rd_data  <= mem[rd_ptr];
            rd_valid <= 1'b1;
            rd_ptr   <= rd_ptr + ADDR_W'(1);
            rd_left  <= rd_left - FILL_W'(1);
        end else begin
            rd_valid <= 1'b0;
        end
    end

    always_comb rd_empty = (rd_left == '0);

endmodule

// File: rtl/rbcap_top.sv
module rbcap_top
    import rbcap_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int DLY_W   = 16,
    parameter int ADDR_W  = 10,
    parameter int DEV_W   = $clog2(MAX_DEV + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dvalid_n,
    input  logic               conv_lvl,
    input  logic               sdata_in,
    input  logic               ext_dclk,
    input  logic [DEV_W-1:0]   cfg_devs,
    input  logic [DLY_W-1:0]   cfg_delay,
    input  logic [1:0]         cfg_rate,
    input  logic               cfg_ext_dclk,
    input  logic               cfg_ext_conv,
    input  logic               rd_start,
    input  logic               rd_en,
    output logic               dclk_out,
    output logic               xmit_n,
    output logic               cfg_conflict,
    output logic               overrun,
    output logic [WORD_W:0]    rd_data,
    output logic               rd_valid,
    output logic               rd_empty
);

    localparam int ENT_W = $bits(cap_word_t);

    logic      run;
    logic      smp_stb;
    logic      smp_bit;
    logic      fall_stb;
    logic      wr_en;
    cap_word_t wr_word;

    always_ff @(posedge clk) begin
        if (rst) cfg_conflict <= 1'b0;
        else     cfg_conflict <= cfg_ext_dclk && cfg_ext_conv;
    end

    rb_dclk_gen u_dclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .rate     (cfg_rate),
        .ext_sel  (cfg_ext_dclk),
        .ext_dclk (ext_dclk),
        .din      (sdata_in),
        .smp_stb  (smp_stb),
        .smp_bit  (smp_bit),
        .fall_stb (fall_stb),
        .dclk_out (dclk_out)
    );

    rb_sequencer #(
        .MAX_DEV (MAX_DEV),
        .DEV_W   (DEV_W),
        .DLY_W   (DLY_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .dvalid_n    (dvalid_n),
        .conv_lvl    (conv_lvl),
        .cfg_devs    (cfg_devs),
        .cfg_delay   (cfg_delay),
        .ext_sel     (cfg_ext_dclk),
        .block_start (cfg_conflict),
        .smp_stb     (smp_stb),
        .smp_bit     (smp_bit),
        .fall_stb    (fall_stb),
        .run         (run),
        .xmit_n      (xmit_n),
        .overrun     (overrun),
        .wr_en       (wr_en),
        .wr_word     (wr_word)
    );

    rb_ring #(
        .ADDR_W (ADDR_W),
        .ENT_W  (ENT_W)
    ) u_ring (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_word),
        .rd_start (rd_start),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_empty (rd_empty)
    );

endmodule

// File: rtl/rbcap_checker.sv
module rbcap_checker (
    input logic clk,
    input logic rst,
    input logic xmit_n,
    input logic dclk_out,
    input logic cfg_ext_dclk,
    input logic overrun,
    input logic rd_en,
    input logic rd_valid,
    input logic rd_empty
);

    p_dclk_in_xmit_r3: assert property (@(posedge clk) disable iff (rst)
        dclk_out |-> !xmit_n);

    p_xmit_release_low_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(xmit_n) |-> !dclk_out);

    p_ext_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_ext_dclk |=> !dclk_out);

    p_overrun_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> !overrun);

    p_read_latency_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en && !rd_empty));

endmodule

bind rbcap_top rbcap_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .xmit_n       (xmit_n),
    .dclk_out     (dclk_out),
    .cfg_ext_dclk (cfg_ext_dclk),
    .overrun      (overrun),
    .rd_en        (rd_en),
    .rd_valid     (rd_valid),
    .rd_empty     (rd_empty)
);

// File: tb/rbcap_top_tb.sv
module rbcap_top_tb;

    localparam int CLK_PERIOD = 50;
    localparam int TB_MAX_DEV = 4;
    localparam int TB_DEV_W   = 3;
    localparam int TB_DLY_W   = 8;
    localparam int TB_ADDR_W  = 4;
    localparam int TB_DEPTH   = 1 << TB_ADDR_W;
    localparam int WATCHDOG   = 150000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                dvalid_n = 1'b1;
    logic                conv_lvl = 1'b0;
    logic                sdata_in = 1'b0;
    logic                ext_dclk = 1'b0;
    logic [TB_DEV_W-1:0] cfg_devs = 3'd1;
    logic [TB_DLY_W-1:0] cfg_delay = '0;
    logic [1:0]          cfg_rate = 2'd0;
    logic                cfg_ext_dclk = 1'b0;
    logic                cfg_ext_conv = 1'b0;
    logic                rd_start = 1'b0;
    logic                rd_en = 1'b0;
    logic                dclk_out;
    logic                xmit_n;
    logic                cfg_conflict;
    logic                overrun;
    logic [20:0]         rd_data;
    logic                rd_valid;
    logic                rd_empty;

    rbcap_top #(
        .MAX_DEV (TB_MAX_DEV),
        .DLY_W   (TB_DLY_W),
        .ADDR_W  (TB_ADDR_W),
        .DEV_W   (TB_DEV_W)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .dvalid_n     (dvalid_n),
        .conv_lvl     (conv_lvl),
        .sdata_in     (sdata_in),
        .ext_dclk     (ext_dclk),
        .cfg_devs     (cfg_devs),
        .cfg_delay    (cfg_delay),
        .cfg_rate     (cfg_rate),
        .cfg_ext_dclk (cfg_ext_dclk),
        .cfg_ext_conv (cfg_ext_conv),
        .rd_start     (rd_start),
        .rd_en        (rd_en),
        .dclk_out     (dclk_out),
        .xmit_n       (xmit_n),
        .cfg_conflict (cfg_conflict),
        .overrun      (overrun),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_empty     (rd_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          vectors = 0;
    int          misses = 0;
    logic [20:0] exp_q[$];
    logic        frame_bits[$];
    int          bit_idx = 0;
    int          ext_ph = 0;
    int          rise_cnt = 0;
    int          ovr_cnt = 0;
    int          t_rise1 = 0;
    int          t_rise2 = 0;
    int          cyc = 0;
    int          frame_no = 0;
    logic        prev_x = 1'b1;
    logic        prev_d = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // converter chain model plus per-clock compare
    always @(negedge clk) begin
        if (!rst) begin
            check(!(dclk_out && xmit_n), "R3 dclk only during transmit", dclk_out, 0);
            if (overrun) ovr_cnt++;
            if (dclk_out && !prev_d) begin
                rise_cnt++;
                if (rise_cnt == 1) t_rise1 = cyc;
                if (rise_cnt == 2) t_rise2 = cyc;
            end
            if (!cfg_ext_dclk) begin
                if (!xmit_n && prev_x) begin
                    bit_idx = 0;
                    if (frame_bits.size() > 0) sdata_in = frame_bits[0];
                end else if (!xmit_n && prev_d && !dclk_out) begin
                    bit_idx++;
                    if (bit_idx < frame_bits.size()) sdata_in = frame_bits[bit_idx];
                end
            end else begin
                if (!xmit_n && prev_x) begin
                    bit_idx = 0;
                    ext_ph = 0;
                end
                if (!xmit_n && bit_idx < frame_bits.size()) begin
                    if (ext_ph == 0) begin
                        sdata_in = frame_bits[bit_idx];
                        ext_dclk = 1'b0;
                    end
                    if (ext_ph == 4) ext_dclk = 1'b1;
                    if (ext_ph == 7) begin
                        ext_ph = 0;
                        bit_idx++;
                    end else begin
                        ext_ph++;
                    end
                end
            end
        end
        prev_x = xmit_n;
        prev_d = dclk_out;
    end

    task automatic run_frame(input int devs, input int dly, input int rate,
                             input bit side, input bit ext, input bit inject);
        int n_eff;
        int cnt;
        int guard;
        logic [19:0] wv;
        @(negedge clk);
        cfg_devs     = TB_DEV_W'(devs);
        cfg_delay    = TB_DLY_W'(dly);
        cfg_rate     = 2'(rate);
        cfg_ext_dclk = ext;
        conv_lvl     = side;
        frame_no++;
        n_eff = (devs == 0) ? 1 : devs;
        frame_bits.delete();
        for (int w = 0; w < 2 * n_eff; w++) begin
            wv = 20'((frame_no * 32'h1357B) ^ (w * 32'h0F0F3) ^ 32'hA5A5A);
            for (int b = 19; b >= 0; b--) frame_bits.push_back(wv[b]);
            exp_q.push_back({side, wv});
            if (exp_q.size() > TB_DEPTH) void'(exp_q.pop_front());
        end
        rise_cnt = 0;
        ovr_cnt  = 0;
        repeat (3) @(negedge clk);
        dvalid_n = 1'b0;
        cnt = 0;
        do begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end while (xmit_n && cnt < dly + 50);
        check(cnt == dly + 2, "R2 start delay", cnt, dly + 2);
        if (inject) begin
            repeat (30) @(negedge clk);
            dvalid_n = 1'b1;
            @(negedge clk);
            dvalid_n = 1'b0;
        end
        guard = 0;
        while (!xmit_n && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        dvalid_n = 1'b1;
        if (!ext) begin
            check(rise_cnt == 40 * n_eff, "R4 bits per readback", rise_cnt, 40 * n_eff);
            check((t_rise2 - t_rise1) == (2 << rate), "R3 dclk period", t_rise2 - t_rise1, 2 << rate);
        end else begin
            check(rise_cnt == 0, "R6 internal clock quiet", rise_cnt, 0);
        end
        check(ovr_cnt == (inject ? 1 : 0), "R10 overrun pulses", ovr_cnt, inject ? 1 : 0);
        repeat (40) @(negedge clk);
        check(xmit_n == 1'b1, "R10 no restart after readback", xmit_n, 1);
    endtask

    task automatic read_all();
        @(negedge clk);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        check(rd_empty == (exp_q.size() == 0), "R9 empty after snapshot", rd_empty, exp_q.size() == 0);
        for (int i = 0; i < exp_q.size(); i++) begin
            rd_en = 1'b1;
            @(negedge clk);
            check(rd_valid == 1'b1, "R9 read valid", rd_valid, 1);
            check(rd_data[19:0] == exp_q[i][19:0], "R8 word order", rd_data[19:0], exp_q[i][19:0]);
            check(rd_data[20] == exp_q[i][20], "R5 side tag", rd_data[20], exp_q[i][20]);
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid == 1'b0, "R9 read while empty", rd_valid, 0);
        check(rd_empty == 1'b1, "R9 empty after drain", rd_empty, 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int lows;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(xmit_n == 1'b1, "R1 xmit_n", xmit_n, 1);
        check(dclk_out == 1'b0, "R1 dclk_out", dclk_out, 0);
        check(overrun == 1'b0, "R1 overrun", overrun, 0);
        check(cfg_conflict == 1'b0, "R1 conflict", cfg_conflict, 0);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        check(rd_empty == 1'b1, "R1 rd_empty", rd_empty, 1);

        run_frame(1, 0, 0, 1'b0, 1'b0, 1'b0);
        read_all();
        run_frame(2, 5, 1, 1'b1, 1'b0, 1'b0);
        run_frame(0, 3, 2, 1'b0, 1'b0, 1'b0);   // R4 zero devices acts as one
        run_frame(1, 2, 0, 1'b1, 1'b1, 1'b0);   // R6 external clock
        read_all();
        run_frame(4, 1, 3, 1'b0, 1'b0, 1'b1);   // R8 wrap, R10 overrun
        read_all();

        // R7 shared-pin conflict blocks readback
        @(negedge clk);
        cfg_ext_dclk = 1'b1;
        cfg_ext_conv = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(cfg_conflict == 1'b1, "R7 conflict flag", cfg_conflict, 1);
        dvalid_n = 1'b0;
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!xmit_n) lows++;
        end
        check(lows == 0, "R7 no transmit under conflict", lows, 0);
        dvalid_n = 1'b1;
        cfg_ext_dclk = 1'b0;
        cfg_ext_conv = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(cfg_conflict == 1'b0, "R7 conflict clears", cfg_conflict, 0);
        read_all();   // R7 memory unchanged

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule